// File: doc/BRIEF.md
# GPIO Interrupt Event Aggregator

This block watches a wide set of asynchronous general-purpose inputs and turns per-pin activity into interrupt events. Each input is first brought into the local clock domain through a short flop chain. A per-pin two-bit trigger setting then picks what counts as an event on that pin: a rising edge, a falling edge, a low level or a high level. Every event lands in a status bitmap. The bitmap keeps the event until software clears it.

Software reaches two bitmaps over a small word-wide register port: the pending-event status and the interrupt enable. Each bitmap is split into 32-bit banks. A status bit is cleared by writing a one to it. An enable bank is written as a whole word. One registered interrupt line reports whether any pin has both its status bit and its enable bit set.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset, every status bit and every enable bit reads 0, and `irq_out` is 0.
- R2: With trigger pair {select,invert} = 2'b00, a 0-to-1 change on a pin's synchronized input sets its status bit. A 1-to-0 change sets nothing.
- R3: With trigger pair 2'b01, a 1-to-0 change sets the pin's status bit. A 0-to-1 change sets nothing.
- R4: With trigger pair 2'b10, the status bit is set on every cycle the synchronized input is low. A clear issued while the input stays low has no lasting effect, and a clear issued after the input returns high removes the bit.
- R5: With trigger pair 2'b11, the status bit is set on every cycle the synchronized input is high, with the same clear behaviour as R4 but for the opposite level.
- R6: A status write clears exactly the bits written as 1 in the addressed bank. Bits written as 0 keep their value, and no status bit falls without a status write.
- R7: Status bits record events whether or not the pin is enabled. Enabling a pin later raises `irq_out` for an event that is already stored.
- R8: `irq_out` equals, one clock later, the OR over all banks of status AND enable. Writing 0 to an enable bank masks every pin of that bank.
- R9: When a new event and a clearing write hit the same status bit on the same clock edge, the bit ends up set.
- R10: Bits for pin indices at or above `NUM_PINS` read as 0 in both the status and the enable bitmaps, including after all-ones writes.
- R11: Register address is {kind, bank}: kind 0 selects status and kind 1 selects enable, and bank selects the 32-bit word (pin = 32*bank + bit). Read data appears on `reg_rdata` one clock after `reg_rd` and is held until the next read. A bank index at or above the bank count reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Asynchronous GPIO input levels |
| trig_sel | input | NUM_PINS | Per-pin trigger select: 0 edge, 1 level |
| trig_inv | input | NUM_PINS | Per-pin trigger invert |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | {kind, bank} register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Combined registered interrupt |

## Verification
The four trigger modes run on pins in different banks. Rising and falling modes each get both input directions, which shows that edge polarity is decoded and not merely activity. Level pins get a clear while the level is still active and another after it drops, which separates level re-arming from edge latching. A write-zero to status, an enable applied after an event, an enable bank set to zero, an event that meets a clear on the same edge, and all-ones writes to the partial top bank each isolate one rule of the status and enable logic.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int WORD_W = 32;

    // Trigger pair encoding {select, invert}
    typedef enum logic [1:0] {
        TRIG_RISE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_LOW  = 2'b10,
        TRIG_HIGH = 2'b11
    } trig_mode_e;

    function automatic int unsigned bank_count(input int unsigned pins);
        return (pins + WORD_W - 1) / WORD_W;
    endfunction

    function automatic int unsigned bank_bits(input int unsigned nbanks);
        return (nbanks > 1) ? $clog2(nbanks) : 1;
    endfunction

    // Number of implemented bits in bank b
    function automatic int unsigned bank_valid(input int unsigned pins, input int unsigned b);
        int unsigned rest;
        rest = pins - b * WORD_W;
        return (rest >= WORD_W) ? WORD_W : rest;
    endfunction

    function automatic logic trig_hit(input trig_mode_e mode, input logic cur, input logic prev);
        logic hit;
        case (mode)
            TRIG_RISE: hit = cur & ~prev;
            TRIG_FALL: hit = ~cur & prev;
            TRIG_LOW:  hit = ~cur;
            default:   hit = cur;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 95,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[s] <= '0;
                end else if (s == 0) begin
                    chain[s] <= d_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s - 1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 95
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] sel,
    input  logic [WIDTH-1:0] inv,
    output logic [WIDTH-1:0] evt
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level;
    end

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            trig_mode_e mode;
            assign mode   = trig_mode_e'({sel[i], inv[i]});
            assign evt[i] = trig_hit(mode, level[i], prev_q[i]);
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int VALID_BITS = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] evt,
    input  logic              clr_wr,
    input  logic              en_wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] status_q,
    output logic [WORD_W-1:0] enable_q,
    output logic              pend
);
    localparam logic [WORD_W-1:0] VALID_MASK = {WORD_W{1'b1}} >> (WORD_W - VALID_BITS);

    logic [WORD_W-1:0] clr_mask;
    assign clr_mask = clr_wr ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            // a fresh event overrides a same-edge clear
            status_q <= ((status_q & ~clr_mask) | evt) & VALID_MASK;
            if (en_wr) enable_q <= wdata & VALID_MASK;
        end
    end

    assign pend = |(status_q & enable_q);
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS    = 95,
    parameter int SYNC_STAGES = 2,
    parameter int NUM_BANKS   = bank_count(NUM_PINS),
    parameter int BANK_W      = bank_bits(NUM_BANKS),
    parameter int ADDR_W      = BANK_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] trig_sel,
    input  logic [NUM_PINS-1:0] trig_inv,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq_out
);
    localparam int PAD_W = NUM_BANKS * WORD_W;

    logic [NUM_PINS-1:0] level_s;
    logic [NUM_PINS-1:0] evt;
    logic [PAD_W-1:0]    evt_pad;
    logic [PAD_W-1:0]    status_all;
    logic [PAD_W-1:0]    enable_all;
    logic [NUM_BANKS-1:0] bank_pend;
    logic                sel_enable;
    logic [BANK_W-1:0]   bank_idx;

    assign sel_enable = reg_addr[ADDR_W-1];
    assign bank_idx   = reg_addr[BANK_W-1:0];

    gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pin_in),
        .d_out (level_s)
    );

    gpio_irq_detect #(.WIDTH(NUM_PINS)) u_detect (
        .clk   (clk),
        .rst   (rst),
        .level (level_s),
        .sel   (trig_sel),
        .inv   (trig_inv),
        .evt   (evt)
    );

    always_comb begin
        evt_pad = '0;
        evt_pad[NUM_PINS-1:0] = evt;
    end

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit;
            assign hit = reg_wr && (int'(bank_idx) == b);
            gpio_irq_bank #(.VALID_BITS(bank_valid(NUM_PINS, b))) u_bank (
                .clk      (clk),
                .rst      (rst),
                .evt      (evt_pad[b*WORD_W +: WORD_W]),
                .clr_wr   (hit && !sel_enable),
                .en_wr    (hit && sel_enable),
                .wdata    (reg_wdata),
                .status_q (status_all[b*WORD_W +: WORD_W]),
                .enable_q (enable_all[b*WORD_W +: WORD_W]),
                .pend     (bank_pend[b])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
            irq_out   <= 1'b0;
        end else begin
            irq_out <= |bank_pend;
            if (reg_rd) begin
                if (int'(bank_idx) < NUM_BANKS) begin
                    reg_rdata <= sel_enable ? enable_all[int'(bank_idx)*WORD_W +: WORD_W]
                                            : status_all[int'(bank_idx)*WORD_W +: WORD_W];
                end else begin
                    reg_rdata <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
    parameter int NUM_PINS = 95,
    parameter int PAD_W    = 96
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [31:0]      reg_rdata,
    input logic             irq_out,
    input logic [PAD_W-1:0] status_all,
    input logic [PAD_W-1:0] enable_all
);
    // R1: state is clear on the first cycle after reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_all == '0 && enable_all == '0 && !irq_out));

    // R8: combined output follows masked status one cycle later
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (irq_out == |($past(status_all) & $past(enable_all))));

    // R6: without a write, no status bit falls
    a_r6_no_spont_clear: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ((status_all & $past(status_all)) == $past(status_all)));

    // R10: unimplemented positions stay zero
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ((status_all >> NUM_PINS) == '0) && ((enable_all >> NUM_PINS) == '0));

    // R11: read data holds between reads
    a_r11_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.NUM_PINS(NUM_PINS), .PAD_W(PAD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rdata  (reg_rdata),
    .irq_out    (irq_out),
    .status_all (status_all),
    .enable_all (enable_all)
);

// File: tb/sim_gpio_irq_agg.sv
module sim_gpio_irq_agg;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 95;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] trig_sel = '0;
    logic [NP-1:0] trig_inv = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          irq_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    event  chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_agg u0 (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .trig_sel  (trig_sel),
        .trig_inv  (trig_inv),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    // Monitor: pops expected items and compares against the outputs
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? {31'd0, irq_out} : reg_rdata;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    function automatic logic [2:0] st_addr(input int b); return {1'b0, 2'(b)}; endfunction
    function automatic logic [2:0] en_addr(input int b); return {1'b1, 2'(b)}; endfunction

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_read(input logic [2:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(posedge clk);
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        sb_q.push_back(it);
        -> chk_ev;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        settle(3);
        rst = 1'b0;

        // R1 reset state
        for (int b = 0; b < 3; b++) begin
            expect_read(st_addr(b), 32'h0, "R1 status after reset");
            expect_read(en_addr(b), 32'h0, "R1 enable after reset");
        end
        expect_irq(1'b0, "R1 irq after reset");

        // R2 rising on pin 3 (bank0 bit3)
        pin_in[3] = 1'b1; settle(4);
        expect_read(st_addr(0), 32'h8, "R2 rise sets");
        expect_irq(1'b0, "R7 irq masked while disabled");
        bus_write(st_addr(0), 32'h0);
        expect_read(st_addr(0), 32'h8, "R6 write zero keeps");
        bus_write(en_addr(0), 32'h8);
        expect_irq(1'b1, "R7 late enable exposes event");
        bus_write(st_addr(0), 32'h8);
        expect_read(st_addr(0), 32'h0, "R6 write one clears");
        expect_irq(1'b0, "R8 irq drops after clear");
        pin_in[3] = 1'b0; settle(4);
        expect_read(st_addr(0), 32'h0, "R2 fall ignored in rise mode");

        // R3 falling on pin 40 (bank1 bit8)
        trig_inv[40] = 1'b1;
        pin_in[40] = 1'b1; settle(4);
        expect_read(st_addr(1), 32'h0, "R3 rise ignored in fall mode");
        pin_in[40] = 1'b0; settle(4);
        expect_read(st_addr(1), 32'h100, "R3 fall sets");

        // R8 enable bank masking
        bus_write(en_addr(1), 32'h100);
        expect_irq(1'b1, "R8 bank1 enabled");
        bus_write(en_addr(1), 32'h0);
        expect_irq(1'b0, "R8 zero enable word masks");
        expect_read(st_addr(1), 32'h100, "R8 status kept while masked");
        bus_write(st_addr(1), 32'hFFFF_FFFF);
        expect_read(st_addr(1), 32'h0, "R6 all ones clears bank");

        // R4 level low on pin 70 (bank2 bit6)
        pin_in[70] = 1'b1; settle(4);
        trig_sel[70] = 1'b1;
        bus_write(st_addr(2), 32'h40);
        expect_read(st_addr(2), 32'h0, "R4 idle high no event");
        pin_in[70] = 1'b0; settle(4);
        expect_read(st_addr(2), 32'h40, "R4 low sets");
        bus_write(st_addr(2), 32'h40);
        expect_read(st_addr(2), 32'h40, "R4 clear during low re-sets");
        pin_in[70] = 1'b1; settle(4);
        bus_write(st_addr(2), 32'h40);
        expect_read(st_addr(2), 32'h0, "R4 clear after release");

        // R5 level high on pin 94 (bank2 bit30)
        trig_sel[94] = 1'b1; trig_inv[94] = 1'b1;
        settle(2);
        expect_read(st_addr(2), 32'h0, "R5 idle low no event");
        pin_in[94] = 1'b1; settle(4);
        expect_read(st_addr(2), 32'h4000_0000, "R5 high sets");
        bus_write(st_addr(2), 32'h4000_0000);
        expect_read(st_addr(2), 32'h4000_0000, "R5 clear during high re-sets");
        pin_in[94] = 1'b0; settle(4);
        bus_write(st_addr(2), 32'h4000_0000);
        expect_read(st_addr(2), 32'h0, "R5 clear after release");

        // R9 event and clear on the same edge: pin 3 rise
        pin_in[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = st_addr(0); reg_wdata = 32'h8;
        @(negedge clk);
        reg_wr = 1'b0;
        expect_read(st_addr(0), 32'h8, "R9 set wins over clear");

        // R10 / R11 unimplemented bits and bank
        bus_write(en_addr(2), 32'hFFFF_FFFF);
        expect_read(en_addr(2), 32'h7FFF_FFFF, "R10 enable top bit reads zero");
        bus_write(st_addr(2), 32'hFFFF_FFFF);
        expect_read(st_addr(2), 32'h0, "R10 status top bank zero");
        expect_read(3'b011, 32'h0, "R11 bank beyond count reads zero");
        expect_read(en_addr(0), 32'h8, "R11 enable kind decode");

        settle(2);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule